// File: doc/BRIEF.md
# SCSI Host Controller Register Bank

This block holds the byte-addressed control and status registers of a SCSI host controller. A host bus port writes one byte per cycle at an 8-bit offset. Registers 24 or 32 bits wide are spread over consecutive offsets, least significant byte at the lowest offset, so software builds them one byte lane at a time. A plain read port returns the stored byte one cycle after the read address is presented.

Several offsets do more than store data. Some bits trigger actions and are never stored. One status register keeps its low nibble across host writes. Writing the top byte of the script pointer can start the script engine. The SCSI bus reset is raised only on the write that first sets its status bit. All actions leave the block as one-cycle registered pulses, for use by the script engine, the bus interface and the interrupt logic.

Offsets are classified as follows:
- Storing offsets keep the written byte, minus any reserved bits.
- Read-only offsets drop writes without complaint.
- Any other offset raises a sticky error flag. An input clears the flag.

Top module: `scsi_regbank`

## Requirements
- R1: A write to one offset of a multi-byte register (0x10-0x13, 0x1c-0x1f, 0x24-0x26, 0x28-0x37, 0xa0-0xbb, 0xc0-0xcf, 0xd4-0xdf) replaces only that byte. The other bytes of the register keep their values.
- R2: A write to the status register at 0x14 stores data bits 7:4 and keeps bits 3:0. Bit 2 is the interrupt flag: writing it as one clears it and pulses `irq_eval_pulse`. The input `intf_set` sets that bit.
- R3: At 0x14, data bit 7 pulses `abort_pulse`. Data bit 6 pulses `srst_pulse`, clears every register to zero and clears `bad_wr_err`.
- R4: While `wait_resel` is high, writing 0x14 with data bit 5 set copies offsets 0x28-0x2b into 0x2c-0x2f and pulses both `wake_pulse` and `start_pulse`. While `wait_resel` is low, the same write gives neither pulse.
- R5: A write to 0x2f stores the byte. It pulses `start_pulse` only when bit 0 of 0x38 (manual start) is clear and `eng_running` is low.
- R6: A write to 0x3b stores the byte with bits 2 and 6 forced to zero. Data bit 2 pulses `start_pulse` when `eng_running` is low.
- R7: Writing 0x01 with bit 3 set raises `bus_rst_pulse` and `rst_irq_pulse` and sets bit 1 of 0x0c, but only if that bit was clear. Writing bit 3 as zero clears the status bit. Bit 5 of 0x01 is never stored.
- R8: Reserved bits are masked: 0x06 and 0x1b keep bits 3:0 only, and 0x02 stores bits 0 and 3 as zero.
- R9: Writes to 0x0a-0x0f change nothing and raise no error.
- R10: Offsets 0x5c-0x9f form a scratch array stored byte by byte. Word (offset-0x58)>>2 is selected and offset[1:0] picks the lane. Offset 0x58 is not part of it.
- R11: Writes to 0x39, 0x40 or 0x41 store the byte and pulse `irq_eval_pulse`.
- R12: A write to any offset not listed sets `bad_wr_err` and changes no register. `err_clr` clears the flag.
- R13: Every pulse is high for exactly the one cycle after the clock edge that takes the write. Synchronous reset clears all registers, pulses and the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | AW | Write offset |
| wr_data | input | DW | Write byte |
| rd_addr | input | AW | Read offset |
| eng_running | input | 1 | Script engine is running |
| wait_resel | input | 1 | Script engine waits for reselection |
| intf_set | input | 1 | Engine sets the interrupt flag at 0x14 bit 2 |
| err_clr | input | 1 | Clears the bad-write flag |
| rd_data | output | DW | Registered read byte |
| bus_rst_pulse | output | 1 | Assert SCSI bus reset |
| rst_irq_pulse | output | 1 | Raise SCSI reset interrupt |
| start_pulse | output | 1 | Start script execution |
| abort_pulse | output | 1 | Raise DMA abort interrupt |
| srst_pulse | output | 1 | Software reset issued |
| irq_eval_pulse | output | 1 | Recompute interrupt line |
| wake_pulse | output | 1 | Leave the reselection wait |
| bad_wr_err | output | 1 | Sticky flag for writes to unlisted offsets |

## Verification
The assertions assume a single byte write per cycle. They also assume that `eng_running`, `wait_resel` and `intf_set` change only between clock edges. The status-nibble check further assumes that `intf_set` is not raised in the same cycle as a write to 0x14. The stimulus drives every input on the falling edge. It raises `intf_set` only in cycles with no write, so the engine-side set never overlaps a host write of the same status byte. Reads and pulse checks are taken on the falling edge after the capturing edge.

// File: rtl/srb_pkg.sv
package srb_pkg;
  typedef enum logic [2:0] {
    K_BAD, K_IGN, K_STORE, K_CTL1, K_ISTAT, K_PTRTOP, K_DCTL, K_IRQEN
  } kind_e;

  localparam logic [7:0] OFF_SSTAT  = 8'h0c;
  localparam logic [7:0] OFF_ISTAT  = 8'h14;
  localparam logic [7:0] OFF_NXADDR = 8'h28;
  localparam logic [7:0] OFF_SPTR   = 8'h2c;
  localparam logic [7:0] OFF_DMODE  = 8'h38;
  localparam int PTR_BYTES = 4;

  localparam int CTL1_BUSRST = 3;
  localparam int SSTAT_RSTST = 1;
  localparam int IST_ABORT   = 7;
  localparam int IST_SRST    = 6;
  localparam int IST_SIGP    = 5;
  localparam int IST_INTF    = 2;
  localparam int DCTL_STEP   = 2;
  localparam int DMODE_MAN   = 0;

  typedef struct packed {
    logic bus_rst;
    logic start;
    logic abort;
    logic srst;
    logic irq_eval;
    logic wake;
  } fx_t;
endpackage

// File: rtl/srb_decode.sv
module srb_decode
  import srb_pkg::*;
(
  input  logic [7:0] addr,
  output kind_e      kind,
  output logic [7:0] keep
);
  always_comb begin
    kind = K_BAD;
    keep = 8'hff;
    case (addr)
      8'h00, 8'h03, 8'h04, 8'h05, 8'h08, 8'h16, 8'h17, 8'h21, 8'h22,
      8'h38, 8'h3a, 8'h48, 8'h4a, 8'h4b, 8'h4d, 8'h4e, 8'h4f, 8'h56,
      8'h57: kind = K_STORE;
      8'h01: begin kind = K_CTL1;  keep = 8'hdf; end
      8'h02: begin kind = K_STORE; keep = 8'hf6; end
      8'h06: begin kind = K_STORE; keep = 8'h0f; end
      8'h1a: begin kind = K_STORE; keep = 8'h08; end
      8'h1b: begin kind = K_STORE; keep = 8'h0f; end
      8'h07, 8'h0a, 8'h0b, 8'h0c, 8'h0d, 8'h0e, 8'h0f, 8'h18, 8'h47,
      8'h49: kind = K_IGN;
      8'h14: kind = K_ISTAT;
      8'h2f: kind = K_PTRTOP;
      8'h3b: begin kind = K_DCTL;  keep = 8'hbb; end
      8'h39, 8'h40, 8'h41: kind = K_IRQEN;
      default: begin
        if (addr inside {[8'h10:8'h13], [8'h1c:8'h1f], [8'h24:8'h26],
                         [8'h28:8'h2e], [8'h30:8'h37], [8'h5c:8'h9f],
                         [8'ha0:8'hbb], [8'hc0:8'hcf], [8'hd4:8'hdf]})
          kind = K_STORE;
      end
    endcase
  end
endmodule

// File: rtl/srb_store.sv
module srb_store
  import srb_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_all,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          copy_ptr,
  input  logic          stat_set,
  input  logic          stat_clr,
  input  logic          intf_set,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] istat_q,
  output logic          stat_rst_q,
  output logic          man_q
);
  localparam int NB = 1 << AW;

  logic [DW-1:0] mem [NB];

  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      for (int i = 0; i < NB; i++) mem[i] <= '0;
    end else begin
      if (we) mem[waddr] <= wdata;
      if (copy_ptr)
        for (int i = 0; i < PTR_BYTES; i++)
          mem[int'(OFF_SPTR) + i] <= mem[int'(OFF_NXADDR) + i];
      if (stat_set)      mem[OFF_SSTAT][SSTAT_RSTST] <= 1'b1;
      else if (stat_clr) mem[OFF_SSTAT][SSTAT_RSTST] <= 1'b0;
      if (intf_set)      mem[OFF_ISTAT][IST_INTF] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end

  assign istat_q    = mem[OFF_ISTAT];
  assign stat_rst_q = mem[OFF_SSTAT][SSTAT_RSTST];
  assign man_q      = mem[OFF_DMODE][DMODE_MAN];
endmodule

// File: rtl/srb_fx.sv
module srb_fx
  import srb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  fx_t  req,
  input  logic bad_wr,
  input  logic err_clr,
  input  logic clr_all,
  output fx_t  pulse,
  output logic err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pulse <= '0;
      err   <= 1'b0;
    end else begin
      pulse <= req;
      if (clr_all)      err <= 1'b0;
      else if (bad_wr)  err <= 1'b1;
      else if (err_clr) err <= 1'b0;
    end
  end
endmodule

// File: rtl/scsi_regbank.sv
module scsi_regbank
  import srb_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  input  logic          eng_running,
  input  logic          wait_resel,
  input  logic          intf_set,
  input  logic          err_clr,
  output logic [DW-1:0] rd_data,
  output logic          bus_rst_pulse,
  output logic          rst_irq_pulse,
  output logic          start_pulse,
  output logic          abort_pulse,
  output logic          srst_pulse,
  output logic          irq_eval_pulse,
  output logic          wake_pulse,
  output logic          bad_wr_err
);
  kind_e         kind;
  logic [7:0]    keep;
  logic [DW-1:0] istat_q, st_data;
  logic          stat_rst_q, man_q, st_we, is_ist, stat_clr;
  fx_t           req, pulse;

  srb_decode u_dec (.addr(wr_addr), .kind(kind), .keep(keep));

  always_comb begin
    is_ist   = wr_en && (kind == K_ISTAT);
    st_we    = wr_en && (kind != K_BAD) && (kind != K_IGN);
    st_data  = wr_data & keep;
    if (kind == K_ISTAT) begin
      st_data[7:4] = wr_data[7:4];
      st_data[3:0] = istat_q[3:0];
      if (wr_data[IST_INTF]) st_data[IST_INTF] = 1'b0;
    end
    stat_clr     = wr_en && (kind == K_CTL1) && !wr_data[CTL1_BUSRST];
    req.bus_rst  = wr_en && (kind == K_CTL1) && wr_data[CTL1_BUSRST] && !stat_rst_q;
    req.wake     = is_ist && wr_data[IST_SIGP] && wait_resel;
    req.start    = (wr_en && (kind == K_PTRTOP) && !man_q && !eng_running)
                || (wr_en && (kind == K_DCTL) && wr_data[DCTL_STEP] && !eng_running)
                || req.wake;
    req.abort    = is_ist && wr_data[IST_ABORT];
    req.srst     = is_ist && wr_data[IST_SRST];
    req.irq_eval = (wr_en && (kind == K_IRQEN)) || (is_ist && wr_data[IST_INTF]);
  end

  srb_store #(.AW(AW), .DW(DW)) u_store (
    .clk(clk), .rst(rst), .clr_all(req.srst),
    .we(st_we), .waddr(wr_addr), .wdata(st_data),
    .copy_ptr(req.wake), .stat_set(req.bus_rst), .stat_clr(stat_clr),
    .intf_set(intf_set), .raddr(rd_addr), .rdata(rd_data),
    .istat_q(istat_q), .stat_rst_q(stat_rst_q), .man_q(man_q)
  );

  srb_fx u_fx (
    .clk(clk), .rst(rst), .req(req),
    .bad_wr(wr_en && (kind == K_BAD)), .err_clr(err_clr),
    .clr_all(req.srst), .pulse(pulse), .err(bad_wr_err)
  );

  assign bus_rst_pulse  = pulse.bus_rst;
  assign rst_irq_pulse  = pulse.bus_rst;
  assign start_pulse    = pulse.start;
  assign abort_pulse    = pulse.abort;
  assign srst_pulse     = pulse.srst;
  assign irq_eval_pulse = pulse.irq_eval;
  assign wake_pulse     = pulse.wake;
endmodule

// File: rtl/srb_chk.sv
module srb_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       eng_running,
  input logic       intf_set,
  input logic       man,
  input logic       stat_rst,
  input logic [7:0] istat,
  input logic       bus_rst,
  input logic       start,
  input logic       abort,
  input logic       srst,
  input logic       irq_eval,
  input logic       wake,
  input logic       err
);
  assert_fx_after_write_R13: assert property (@(posedge clk) disable iff (rst)
    (start || abort || srst || bus_rst || irq_eval || wake) |-> $past(wr_en));

  assert_busrst_edge_R7: assert property (@(posedge clk) disable iff (rst)
    bus_rst |-> (stat_rst && !$past(stat_rst)));

  assert_wake_starts_R4: assert property (@(posedge clk) disable iff (rst)
    wake |-> start);

  assert_ptr_start_gate_R5: assert property (@(posedge clk) disable iff (rst)
    (start && $past(wr_addr) == 8'h2f) |-> (!$past(eng_running) && !$past(man)));

  assert_srst_clears_R3: assert property (@(posedge clk) disable iff (rst)
    srst |-> (istat == 8'h00 && !err));

  assert_istat_low_keep_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 8'h14 && !wr_data[6] && !wr_data[2] && !intf_set)
      |=> (istat[3:0] == $past(istat[3:0])));

  assert_err_cause_R12: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> $past(wr_en));
endmodule

bind scsi_regbank srb_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .eng_running(eng_running), .intf_set(intf_set), .man(man_q),
  .stat_rst(stat_rst_q), .istat(istat_q), .bus_rst(bus_rst_pulse),
  .start(start_pulse), .abort(abort_pulse), .srst(srst_pulse),
  .irq_eval(irq_eval_pulse), .wake(wake_pulse), .err(bad_wr_err)
);

// File: tb/tb_scsi_regbank.sv
`timescale 1ns/1ps
module tb_scsi_regbank;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst = 1'b1, wr_en = 1'b0, eng_running = 1'b0, wait_resel = 1'b0;
  logic       intf_set = 1'b0, err_clr = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0, rd_data;
  logic       bus_rst_pulse, rst_irq_pulse, start_pulse, abort_pulse;
  logic       srst_pulse, irq_eval_pulse, wake_pulse, bad_wr_err;
  int total = 0, bad = 0;

  scsi_regbank dut (.*);

  // pulse vector: {bus_rst, rst_irq, start, abort, srst, irq_eval, wake}
  localparam logic [6:0] P_NONE = 7'h00, P_BRST = 7'h60, P_START = 7'h10,
    P_ABORT = 7'h08, P_SRST = 7'h04, P_IRQ = 7'h02, P_WAKE = 7'h11;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic pchk(input string req, input logic [6:0] exp);
    chk(req, {1'b0, bus_rst_pulse, rst_irq_pulse, start_pulse, abort_pulse,
              srst_pulse, irq_eval_pulse, wake_pulse}, {1'b0, exp});
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk); rd_addr = a;
    @(negedge clk); chk(req, rd_data, exp);
  endtask

  task automatic pulse_intf();
    @(negedge clk); intf_set = 1'b1;
    @(negedge clk); intf_set = 1'b0;
  endtask

  task automatic clear_err();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  task automatic t_reset();
    pchk("R13 reset pulses", P_NONE);
    chk("R13 reset err", {7'h0, bad_wr_err}, 8'h00);
    rdchk("R13 reset reg00", 8'h00, 8'h00);
    rdchk("R13 reset reg14", 8'h14, 8'h00);
  endtask

  task automatic t_lanes();
    wr(8'h10, 8'h11); wr(8'h11, 8'h22); wr(8'h12, 8'h33); wr(8'h13, 8'h44);
    wr(8'h12, 8'haa);
    pchk("R1 no pulse on lane write", P_NONE);
    rdchk("R1 lane0", 8'h10, 8'h11);
    rdchk("R1 lane1", 8'h11, 8'h22);
    rdchk("R1 lane2 replaced", 8'h12, 8'haa);
    rdchk("R1 lane3", 8'h13, 8'h44);
    wr(8'h24, 8'h01); wr(8'h26, 8'h03); wr(8'h25, 8'h02);
    rdchk("R1 count lane0", 8'h24, 8'h01);
    rdchk("R1 count lane2", 8'h26, 8'h03);
    chk("R1 count write no err", {7'h0, bad_wr_err}, 8'h00);
  endtask

  task automatic t_err();
    wr(8'h27, 8'h5a);
    chk("R12 err set past 24-bit reg", {7'h0, bad_wr_err}, 8'h01);
    rdchk("R12 no store at 0x27", 8'h27, 8'h00);
    wr(8'h50, 8'h77);
    rdchk("R12 no store at 0x50", 8'h50, 8'h00);
    chk("R12 err sticky", {7'h0, bad_wr_err}, 8'h01);
    clear_err();
    chk("R12 err cleared", {7'h0, bad_wr_err}, 8'h00);
  endtask

  task automatic t_masks();
    wr(8'h06, 8'hff); rdchk("R8 dest id nibble", 8'h06, 8'h0f);
    wr(8'h1b, 8'ha5); rdchk("R8 test3 nibble", 8'h1b, 8'h05);
    wr(8'h02, 8'hff); rdchk("R8 ctl2 flags zero", 8'h02, 8'hf6);
  endtask

  task automatic t_ctl1();
    wr(8'h01, 8'h28);
    pchk("R7 bus reset pulse", P_BRST);
    @(negedge clk);
    pchk("R13 pulse one cycle", P_NONE);
    rdchk("R7 ctl1 start bit dropped", 8'h01, 8'h08);
    rdchk("R7 status set", 8'h0c, 8'h02);
    wr(8'h01, 8'h08);
    pchk("R7 no repeat while set", P_NONE);
    wr(8'h01, 8'h00);
    rdchk("R7 status cleared", 8'h0c, 8'h00);
    wr(8'h01, 8'h08);
    pchk("R7 reset again after clear", P_BRST);
  endtask

  task automatic t_readonly();
    wr(8'h0c, 8'hff);
    rdchk("R9 0x0c unchanged", 8'h0c, 8'h02);
    wr(8'h0a, 8'hff);
    rdchk("R9 0x0a unchanged", 8'h0a, 8'h00);
    chk("R9 no err", {7'h0, bad_wr_err}, 8'h00);
  endtask

  task automatic t_scratch();
    wr(8'h5c, 8'h12); wr(8'h9f, 8'h34); wr(8'h7e, 8'h56);
    rdchk("R10 scratch first", 8'h5c, 8'h12);
    rdchk("R10 scratch last", 8'h9f, 8'h34);
    rdchk("R10 scratch mid lane", 8'h7e, 8'h56);
    chk("R10 no err", {7'h0, bad_wr_err}, 8'h00);
    wr(8'h58, 8'h99);
    chk("R10 0x58 outside array", {7'h0, bad_wr_err}, 8'h01);
    rdchk("R10 0x58 not stored", 8'h58, 8'h00);
    clear_err();
  endtask

  task automatic t_istat();
    pulse_intf();
    rdchk("R2 intf set", 8'h14, 8'h04);
    wr(8'h14, 8'h34);
    pchk("R2 intf clear re-eval", P_IRQ);
    rdchk("R2 intf cleared upper kept", 8'h14, 8'h30);
    pulse_intf();
    wr(8'h14, 8'h10);
    pchk("R2 no pulse", P_NONE);
    rdchk("R2 low nibble kept", 8'h14, 8'h14);
    wr(8'h14, 8'h80);
    pchk("R3 abort pulse", P_ABORT);
    rdchk("R3 abort stored low kept", 8'h14, 8'h84);
  endtask

  task automatic t_wake();
    wr(8'h28, 8'h01); wr(8'h29, 8'h02); wr(8'h2a, 8'h03); wr(8'h2b, 8'h04);
    wr(8'h2c, 8'hff); wr(8'h2d, 8'hff); wr(8'h2e, 8'hff);
    wr(8'h14, 8'h20);
    pchk("R4 no wake when not waiting", P_NONE);
    rdchk("R4 ptr untouched", 8'h2c, 8'hff);
    wait_resel = 1'b1;
    wr(8'h14, 8'h20);
    wait_resel = 1'b0;
    pchk("R4 wake and start", P_WAKE);
    rdchk("R4 ptr b0", 8'h2c, 8'h01);
    rdchk("R4 ptr b1", 8'h2d, 8'h02);
    rdchk("R4 ptr b2", 8'h2e, 8'h03);
    rdchk("R4 ptr b3", 8'h2f, 8'h04);
  endtask

  task automatic t_ptr_top();
    eng_running = 1'b0;
    wr(8'h38, 8'h00);
    wr(8'h2f, 8'h55);
    pchk("R5 start on top byte", P_START);
    rdchk("R5 top stored", 8'h2f, 8'h55);
    eng_running = 1'b1;
    wr(8'h2f, 8'h66);
    pchk("R5 no start while running", P_NONE);
    eng_running = 1'b0;
    wr(8'h38, 8'h01);
    wr(8'h2f, 8'h77);
    pchk("R5 no start in manual mode", P_NONE);
  endtask

  task automatic t_dctl();
    eng_running = 1'b0;
    wr(8'h3b, 8'hff);
    pchk("R6 step starts", P_START);
    rdchk("R6 bits 2 and 6 dropped", 8'h3b, 8'hbb);
    eng_running = 1'b1;
    wr(8'h3b, 8'h04);
    pchk("R6 no start while running", P_NONE);
    eng_running = 1'b0;
    rdchk("R6 stored zero", 8'h3b, 8'h00);
  endtask

  task automatic t_irqen();
    wr(8'h39, 8'h81); pchk("R11 0x39 re-eval", P_IRQ);
    wr(8'h40, 8'h42); pchk("R11 0x40 re-eval", P_IRQ);
    wr(8'h41, 8'h07); pchk("R11 0x41 re-eval", P_IRQ);
    rdchk("R11 0x40 stored", 8'h40, 8'h42);
    wr(8'h3a, 8'h01); pchk("R11 other offset no pulse", P_NONE);
  endtask

  task automatic t_srst();
    wr(8'h10, 8'h5a);
    wr(8'h50, 8'h01);
    wr(8'h14, 8'h40);
    pchk("R3 soft reset pulse", P_SRST);
    chk("R3 err cleared", {7'h0, bad_wr_err}, 8'h00);
    rdchk("R3 reg 0x10 cleared", 8'h10, 8'h00);
    rdchk("R3 reg 0x14 cleared", 8'h14, 8'h00);
    rdchk("R3 reg 0x0c cleared", 8'h0c, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_lanes();
    t_err();
    t_masks();
    t_ctl1();
    t_readonly();
    t_scratch();
    t_istat();
    t_wake();
    t_ptr_top();
    t_dctl();
    t_irqen();
    t_srst();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule